// File: doc/BRIEF.md
# Filter Configuration Port with Serial Register and Pin-Mode Fallback

This block supplies the gain and bandwidth settings for a dual-channel programmable lowpass filter. A mode input picks where those settings come from. When the mode input is high, the settings come straight from the pins. The two serial-control pins carry the bandwidth code, and two gain pins carry the gain code. When the mode input is low, a four-wire serial port shifts in an 8-bit word. Raising chip select stores that word into a control register, and the filter settings are then decoded from the register.

All serial and pin inputs are sampled on a fast system clock through a synchronizer chain, and their edges are detected in that clock domain. The serial data output always shows the bit leaving the top of the shift register. As a new word is clocked in, the word held before it moves out, most significant bit first. Several devices can therefore share chip select and clock in a daisy chain. In serial mode, the gain-LSB pin turns into an output driven by the register's general-purpose bit. Each commit raises a one-cycle strobe, so downstream logic knows when to retune. The block also decodes the gain code into a linear multiplier and the bandwidth code into a clock-divide exponent.

Top module: `filter_cfg_port`

## Requirements
- R1: After the asynchronous active-low reset, with serial mode selected, the block shows gain code 00, bandwidth code 00, shutdown low, general-purpose output low, serial data output low and no update strobe.
- R2: In serial mode, while chip select is low, each rising serial-clock edge shifts one data bit into an 8-bit shift register, most significant bit first. A rising chip-select edge copies the word into the control register with this map: bit 7 is the gain LSB, bit 6 the gain MSB, bit 5 the bandwidth LSB, bit 4 the bandwidth MSB, bit 1 shutdown, bit 0 the general-purpose output. Bits 3 and 2 have no effect.
- R3: Serial-clock edges while chip select is high leave the shift register unchanged. A chip-select low/high pulse with no clock edges then commits the previously shifted word again.
- R4: The serial data output updates only on falling serial-clock edges, taking the shift-register MSB. Just before the k-th rising edge of a transfer (k = 1..8), it shows bit 8-k of the word held before the transfer.
- R5: The serial data output keeps its value after chip select rises. It is not forced low.
- R6: Each commit produces exactly one update strobe, one system-clock cycle wide. No strobe occurs in pin mode.
- R7: In pin mode, the gain code is {gain-MSB pin, gain-LSB pin} and the bandwidth code is {chip-select pin, serial-clock pin}. Shutdown is low and the general-purpose output enable is low.
- R8: Activity on the chip-select and serial-clock pins in pin mode changes neither the shift register nor the control register. After a return to serial mode, a bare chip-select pulse commits the last serially shifted word.
- R9: The gain multiplier output is 1, 2, 4 and 16 for gain codes 00, 01, 10 and 11.
- R10: The bandwidth divide exponent is 0 when the bandwidth MSB is 1, 2 for code 01, and 4 for code 00. The cutoff is the widest band divided by 2 to this power.
- R11: In serial mode, the general-purpose output enable is high and the general-purpose output equals control-register bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinModeSel | input | 1 | 1 = settings from pins, 0 = settings from serial register |
| csN | input | 1 | Chip select, active low; bandwidth MSB in pin mode |
| sclk | input | 1 | Serial clock; bandwidth LSB in pin mode |
| sdi | input | 1 | Serial data in |
| gainHiPin | input | 1 | Gain MSB in pin mode |
| gainLoPin | input | 1 | Gain LSB in pin mode (the shared pin's input side) |
| sdo | output | 1 | Serial data out, always driven |
| gpOut | output | 1 | General-purpose bit for the shared pin in serial mode |
| gpOutEn | output | 1 | Drive enable for the shared pin |
| gainCode | output | 2 | Active gain code |
| bwCode | output | 2 | Active bandwidth code |
| gainMult | output | 5 | Linear gain multiplier |
| bwDivLog2 | output | 3 | Bandwidth divide exponent |
| shutdown | output | 1 | Shutdown request |
| cfgUpdate | output | 1 | One-cycle strobe on each commit |

## Verification
The assertions take for granted that chip select, serial clock and data in are much slower than the system clock. Each level must stay stable for at least two system cycles, so the synchronizer turns every pin edge into exactly one strobe. They also assume that the serial clock is low whenever chip select changes, and that the mode input does not change in the same cycle as a chip-select edge. The stimulus holds every serial-clock phase for four system cycles and changes data only while the clock is low. It parks chip select high with the clock low before every mode change, and it lets each mode switch settle before any serial traffic.

// File: rtl/filt_cfg_pkg.sv
package filt_cfg_pkg;
  localparam int unsigned REG_W      = 8;
  localparam int unsigned GAIN_LSB_B = 7;
  localparam int unsigned GAIN_MSB_B = 6;
  localparam int unsigned BW_LSB_B   = 5;
  localparam int unsigned BW_MSB_B   = 4;
  localparam int unsigned SHDN_B     = 1;
  localparam int unsigned GPO_B      = 0;

  // strobes from the control side to the register datapath
  typedef struct packed {
    logic shift;  // rising serial clock, chip select low
    logic fall;   // falling serial clock, chip select low
    logic load;   // rising chip select
  } cfgStb_t;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic [W-1:0] stage;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage <= RST_VAL;
        else       stage <= d;
      end
      assign q = stage;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] stage;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage <= {STAGES{RST_VAL}};
        else       stage <= {stage[STAGES-2:0], d};
      end
      assign q = stage[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/cfg_ctrl.sv
module cfg_ctrl
  import filt_cfg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pinModeSel,
  input  logic       csN,
  input  logic       sclk,
  input  logic       sdi,
  input  logic       gainHiPin,
  input  logic       gainLoPin,
  output cfgStb_t    stb,
  output logic       sdiBit,
  output logic       serialEn,
  output logic [1:0] pinGain,
  output logic [1:0] pinBw
);
  localparam int unsigned IN_W = 6;
  // order: mode, csN, sclk, sdi, gainHi, gainLo; idle = pin mode, CS high
  localparam logic [IN_W-1:0] IN_RST = 6'b110000;

  logic [IN_W-1:0] rawIn, syncIn;
  logic modeS, csNS, sclkS, sdiS, gainHiS, gainLoS;
  logic sclkD, csND;

  assign rawIn = {pinModeSel, csN, sclk, sdi, gainHiPin, gainLoPin};

  cfg_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .d   (rawIn),
    .q   (syncIn)
  );

  assign {modeS, csNS, sclkS, sdiS, gainHiS, gainLoS} = syncIn;

  // edge history runs in every mode so a mode change creates no edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkD <= 1'b0;
      csND  <= 1'b1;
    end else begin
      sclkD <= sclkS;
      csND  <= csNS;
    end
  end

  assign serialEn  = !modeS;
  assign stb.shift = serialEn && !csNS && sclkS && !sclkD;
  assign stb.fall  = serialEn && !csNS && !sclkS && sclkD;
  assign stb.load  = serialEn && csNS && !csND;
  assign sdiBit    = sdiS;
  assign pinGain   = {gainHiS, gainLoS};
  assign pinBw     = {csNS, sclkS};

  // R6: a commit edge is never followed by another in the next cycle
  p_load_isolated_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> !stb.load);
endmodule

// File: rtl/cfg_datapath.sv
module cfg_datapath
  import filt_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  cfgStb_t          stb,
  input  logic             sdiBit,
  output logic [REG_W-1:0] ctrlReg,
  output logic             sdo,
  output logic             commitStb
);
  logic [REG_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      ctrlReg   <= '0;
      sdo       <= 1'b0;
      commitStb <= 1'b0;
    end else begin
      if (stb.shift) shiftReg <= {shiftReg[REG_W-2:0], sdiBit};
      if (stb.fall)  sdo      <= shiftReg[REG_W-1];
      if (stb.load)  ctrlReg  <= shiftReg;
      commitStb <= stb.load;
    end
  end

  // R2: the control side never raises two strobes at once
  p_strobe_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));
  // R2: a committed register equals the shift word of the cycle before
  p_commit_copy_r2: assert property (@(posedge clk) disable iff (!rstN)
    commitStb |-> ctrlReg == $past(shiftReg));
  // R5: serial output only moves on a falling clock strobe
  p_sdo_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !stb.fall |=> $stable(sdo));
  // R6: update strobe is one cycle wide
  p_commit_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    commitStb |=> !commitStb);
  // R8: register is untouched without a load strobe
  p_reg_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> $stable(ctrlReg));
endmodule

// File: rtl/filter_cfg_port.sv
module filter_cfg_port
  import filt_cfg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pinModeSel,
  input  logic       csN,
  input  logic       sclk,
  input  logic       sdi,
  input  logic       gainHiPin,
  input  logic       gainLoPin,
  output logic       sdo,
  output logic       gpOut,
  output logic       gpOutEn,
  output logic [1:0] gainCode,
  output logic [1:0] bwCode,
  output logic [4:0] gainMult,
  output logic [2:0] bwDivLog2,
  output logic       shutdown,
  output logic       cfgUpdate
);
  cfgStb_t          stb;
  logic             sdiBit, serialEn;
  logic [1:0]       pinGain, pinBw;
  logic [REG_W-1:0] ctrlReg;
  logic             unusedCtrlBits;

  cfg_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pinModeSel(pinModeSel),
    .csN       (csN),
    .sclk      (sclk),
    .sdi       (sdi),
    .gainHiPin (gainHiPin),
    .gainLoPin (gainLoPin),
    .stb       (stb),
    .sdiBit    (sdiBit),
    .serialEn  (serialEn),
    .pinGain   (pinGain),
    .pinBw     (pinBw)
  );

  cfg_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .sdiBit   (sdiBit),
    .ctrlReg  (ctrlReg),
    .sdo      (sdo),
    .commitStb(cfgUpdate)
  );

  assign unusedCtrlBits = ^ctrlReg[3:2];

  always_comb begin
    if (serialEn) begin
      gainCode = {ctrlReg[GAIN_MSB_B], ctrlReg[GAIN_LSB_B]};
      bwCode   = {ctrlReg[BW_MSB_B], ctrlReg[BW_LSB_B]};
      shutdown = ctrlReg[SHDN_B];
      gpOut    = ctrlReg[GPO_B];
      gpOutEn  = 1'b1;
    end else begin
      gainCode = pinGain;
      bwCode   = pinBw;
      shutdown = 1'b0;
      gpOut    = 1'b0;
      gpOutEn  = 1'b0;
    end
  end

  always_comb begin
    unique case (gainCode)
      2'b00:   gainMult = 5'd1;
      2'b01:   gainMult = 5'd2;
      2'b10:   gainMult = 5'd4;
      default: gainMult = 5'd16;
    endcase
    if (bwCode[1])      bwDivLog2 = 3'd0;
    else if (bwCode[0]) bwDivLog2 = 3'd2;
    else                bwDivLog2 = 3'd4;
  end

  // R9: the multiplier is always a single power of two
  p_gain_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $countones(gainMult) == 1);
  // R6: commits only follow a cycle spent in serial mode
  p_upd_serial_r6: assert property (@(posedge clk) disable iff (!rstN)
    cfgUpdate |-> $past(serialEn));
endmodule

// File: tb/tb_filter_cfg_port.sv
`timescale 1ns/1ps
module tb_filter_cfg_port;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pinModeSel = 1'b0, csN = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic gainHiPin = 1'b0, gainLoPin = 1'b0;
  logic sdo, gpOut, gpOutEn, shutdown, cfgUpdate;
  logic [1:0] gainCode, bwCode;
  logic [4:0] gainMult;
  logic [2:0] bwDivLog2;

  int checks = 0, failures = 0;
  int updExpected = 0, updSeen = 0;
  bit done = 1'b0;
  logic [7:0] expQ[$];
  logic [7:0] shiftModel = 8'h00;
  logic [7:0] lastByte = 8'h00;
  bit prevUpd = 1'b0;

  always #5 clk = ~clk;

  filter_cfg_port dut (
    .clk(clk), .rstN(rstN), .pinModeSel(pinModeSel), .csN(csN), .sclk(sclk),
    .sdi(sdi), .gainHiPin(gainHiPin), .gainLoPin(gainLoPin), .sdo(sdo),
    .gpOut(gpOut), .gpOutEn(gpOutEn), .gainCode(gainCode), .bwCode(bwCode),
    .gainMult(gainMult), .bwDivLog2(bwDivLog2), .shutdown(shutdown),
    .cfgUpdate(cfgUpdate)
  );

  function automatic logic [4:0] multOf(input logic [1:0] g);
    case (g)
      2'b00: return 5'd1;
      2'b01: return 5'd2;
      2'b10: return 5'd4;
      default: return 5'd16;
    endcase
  endfunction

  function automatic logic [2:0] divOf(input logic [1:0] b);
    if (b[1]) return 3'd0;
    return b[0] ? 3'd2 : 3'd4;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // driver: shift one byte, checking the outgoing bits, and push the expectation
  task automatic spiWrite(input logic [7:0] b);
    csN = 1'b0;
    waitN(4);
    for (int i = 7; i >= 0; i--) begin
      sdi = b[i];
      waitN(4);
      check(sdo == shiftModel[i], "R4 sdo before rising edge", sdo, shiftModel[i]);
      sclk = 1'b1;
      waitN(4);
      sclk = 1'b0;
      waitN(4);
    end
    shiftModel = b;
    lastByte = b;
    expQ.push_back(b);
    updExpected++;
    csN = 1'b1;
    waitN(6);
    check(sdo == b[7], "R5 sdo kept after CS rise", sdo, b[7]);
    waitN(6);
    check(sdo == b[7], "R5 sdo still kept", sdo, b[7]);
  endtask

  // monitor: compare every commit against the scoreboard queue
  always @(negedge clk) begin
    if (rstN && cfgUpdate) begin
      logic [7:0] e;
      logic [1:0] eg, eb;
      updSeen++;
      check(!prevUpd, "R6 strobe one cycle", 1, 0);
      if (expQ.size() == 0) begin
        check(1'b0, "R6 unexpected strobe", 1, 0);
      end else begin
        e  = expQ.pop_front();
        eg = {e[6], e[7]};
        eb = {e[4], e[5]};
        check(gainCode == eg, "R2 gain code", gainCode, eg);
        check(bwCode == eb, "R2 bandwidth code", bwCode, eb);
        check(shutdown == e[1], "R2 shutdown bit", shutdown, e[1]);
        check(gpOut == e[0] && gpOutEn, "R11 gp output", {gpOutEn, gpOut}, {1'b1, e[0]});
        check(gainMult == multOf(eg), "R9 gain multiplier", gainMult, multOf(eg));
        check(bwDivLog2 == divOf(eb), "R10 divide exponent", bwDivLog2, divOf(eb));
      end
    end
    prevUpd = rstN && cfgUpdate;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] bytes [5];
    bytes[0] = 8'b1011_0001;
    bytes[1] = 8'b0110_0010;
    bytes[2] = 8'b1100_0011;
    bytes[3] = 8'b0001_1100;
    bytes[4] = 8'b0111_0000;
    waitN(3);
    rstN = 1'b1;
    waitN(5);
    // R1 reset state in serial mode
    check(gainCode == 2'b00 && bwCode == 2'b00, "R1 reset codes", {gainCode, bwCode}, 0);
    check(!shutdown && !gpOut && !sdo && !cfgUpdate, "R1 reset flags",
          {shutdown, gpOut, sdo, cfgUpdate}, 0);
    check(gpOutEn, "R11 enable in serial mode", gpOutEn, 1);
    check(gainMult == 5'd1 && bwDivLog2 == 3'd4, "R9 R10 reset decode",
          {gainMult, bwDivLog2}, {5'd1, 3'd4});

    // R2 R4 R5 several words, each pushing the previous one out
    foreach (bytes[k]) spiWrite(bytes[k]);

    // R3 clocks with CS high, then a bare CS pulse recommits the same word
    sdi = 1'b1;
    for (int i = 0; i < 3; i++) begin
      sclk = 1'b1; waitN(4); sclk = 1'b0; waitN(4);
    end
    check(sdo == lastByte[7], "R3 sdo unchanged with CS high", sdo, lastByte[7]);
    expQ.push_back(lastByte);
    updExpected++;
    csN = 1'b0; waitN(6); csN = 1'b1; waitN(8);
    check(updSeen == updExpected, "R3 recommit count", updSeen, updExpected);

    // R7 pin mode: codes from pins, all four bandwidth codes
    pinModeSel = 1'b1;
    waitN(4);
    for (int c = 0; c < 4; c++) begin
      logic [1:0] g;
      logic [1:0] bw;
      g = 2'(3 - c);
      bw = 2'(c);
      gainHiPin = g[1]; gainLoPin = g[0];
      csN = bw[1]; sclk = bw[0];
      waitN(4);
      check(gainCode == g, "R7 pin gain code", gainCode, g);
      check(bwCode == bw, "R7 pin bandwidth code", bwCode, bw);
      check(!shutdown && !gpOutEn && !gpOut, "R7 pin mode quiet",
            {shutdown, gpOutEn, gpOut}, 0);
      check(gainMult == multOf(g) && bwDivLog2 == divOf(bw), "R9 R10 pin decode",
            {gainMult, bwDivLog2}, {multOf(g), divOf(bw)});
    end
    // R8 serial-pin toggling in pin mode with data high
    sdi = 1'b1;
    for (int i = 0; i < 4; i++) begin
      csN = 1'b0; waitN(3); sclk = 1'b1; waitN(3); sclk = 1'b0; waitN(3); csN = 1'b1; waitN(3);
    end
    csN = 1'b1; sclk = 1'b0;
    waitN(4);
    pinModeSel = 1'b0;
    waitN(6);
    check(sdo == lastByte[7], "R8 sdo unchanged by pin mode", sdo, lastByte[7]);
    expQ.push_back(lastByte);
    updExpected++;
    csN = 1'b0; waitN(6); csN = 1'b1; waitN(8);

    // R4 daisy chain: the recommitted word leaves first
    spiWrite(8'b1010_0101);
    waitN(4);
    check(updSeen == updExpected, "R6 strobe count", updSeen, updExpected);
    check(expQ.size() == 0, "R6 all commits seen", expQ.size(), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule